// File: doc/BRIEF.md
# Tray Hit Multiplicity Summer

This block produces a fast trigger multiplicity for one detector tray. The discriminator hit bits of all 192 channels of a tray enter the block. Each bit is brought into the system clock domain through two flip-flops. The channels are then grouped eight at a time, and a group counts as one if any of its channels is set. Eight board slices each cover three groups and form a 2-bit partial count of 0 to 3. A tray-level adder sums the eight partial counts into a 5-bit total, clamped at 24.

The total leaves the block on a 5-bit output that goes to the trigger receiver. A programmable delay of 0 to 15 system clock cycles lets the output be timed in against the receiver's sampling clock. A programmable stretch holds each non-zero value for a minimum number of cycles, so a short hit still makes a pulse long enough to be sampled.

Two capture modes exist. In self-latch mode every board slice recaptures its partial count on every clock, and no external strobe is needed. In strobe mode each slice captures only once per rising edge of a distributed strobe. The capture happens at a per-board phase offset in clock cycles, which is set from outside after that board's phase has been learned.

Top module: `tray_mult_sum`

## Requirements
- R1: Channel c (bit c of `hits`) belongs to group c/8 and to board slice c/24. A group with one or more hit channels adds exactly one to the total, and further hits in the same group add nothing.
- R2: `mult_out` is the unsigned binary number of hit groups over the whole tray, which is the sum of the eight per-board partial counts (each 0 to 3).
- R3: `mult_out` never exceeds 24, even when every channel is hit.
- R4: While `rst_n` is low at a clock edge, `mult_out` is 0 after that edge.
- R5: In self-latch mode (`strobe_mode` = 0), a hit pattern sampled at clock edge k appears on `mult_out` after edge k+4+`out_delay`, and `trig_strobe` has no effect on the output.
- R6: `out_delay` adds exactly its value (0 to 15) in clock cycles to the latency of R5.
- R7: A non-zero value loaded onto `mult_out` stays unchanged for at least `stretch_cycles` cycles, with 0 treated as 1. A tray total that is non-zero for a single cycle gives exactly max(1, `stretch_cycles`) non-zero output cycles.
- R8: In strobe mode (`strobe_mode` = 1), a board's partial count changes only at that board's capture. Hit changes between strobes do not alter `mult_out`.
- R9: In strobe mode, for a rising edge of `trig_strobe` first sampled at clock edge k, board b captures the hit pattern that was sampled at edge k+1+p. Here p is `board_phase[2b+1:2b]` (0 to 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hits | input | 192 | Discriminator hit bit per channel, asynchronous |
| strobe_mode | input | 1 | 0 = self-latch capture, 1 = capture on distributed strobe |
| trig_strobe | input | 1 | Distributed strobe clock, asynchronous |
| board_phase | input | 16 | Capture phase in cycles, 2 bits per board, board b at bits 2b+1:2b |
| out_delay | input | 4 | Output delay in cycles, 0 to 15 |
| stretch_cycles | input | 4 | Minimum hold of a non-zero output in cycles, 0 acts as 1 |
| mult_out | output | 5 | Tray multiplicity, 0 to 24 |

## Verification
The bench puts several hits into one group and expects them to count once. A design that counted channels instead of groups would report too high a total. The bench also hits every channel and expects the total to stop at 24 rather than wrap or overflow. It measures the exact cycle in which the output moves, for delays of 0, 7 and 15, which exposes an off-by-one in the delay tap selection. Single-cycle hits with stretch values of 6 and 0 catch a hold that is one cycle short or long, and catch a zero setting that suppresses the pulse. In strobe mode two boards with different phases see a hit that arrives just before one of their capture points. A slice that captured at the wrong phase, or that kept following the hits between strobes, would give a total other than the expected one.

// File: rtl/tmult_pkg.sv
// Package: shared constants for the tray multiplicity summer.
// Assumes: widths of programmable fields are fixed for the whole block.
package tmult_pkg;
    localparam int PHASE_W   = 2;   // per-board capture phase field width
    localparam int DELAY_W   = 4;   // output delay field width
    localparam int STRETCH_W = 4;   // stretch length field width
endpackage

// File: rtl/tmult_sync.sv
// Module: tmult_sync
// Brings a vector of asynchronous bits into the clock domain with two flops.
// Assumes: each bit is independent; no coherency across bits is required.
module tmult_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta_q;

    // Two-stage capture of the asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            d_sync <= '0;
        end else begin
            meta_q <= d_async;
            d_sync <= meta_q;
        end
    end
endmodule

// File: rtl/tmult_board.sv
// Module: tmult_board
// One digitizer-board slice: ORs each channel group, counts hit groups and
// registers the partial count, either every cycle or at a phased strobe capture.
// Assumes: grp_hits is already synchronous; strobe_rise is a one-cycle pulse.
module tmult_board #(
    parameter int CPG     = 8,
    parameter int GPB     = 3,
    parameter int PHASE_W = 2,
    parameter int PART_W  = $clog2(GPB + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GPB*CPG-1:0] grp_hits,
    input  logic               strobe_mode,
    input  logic               strobe_rise,
    input  logic [PHASE_W-1:0] phase,
    output logic [PART_W-1:0]  part,
    output logic               capture
);
    logic [GPB-1:0]     grp_any;
    logic [PART_W-1:0]  cnt_now;
    logic               armed_q;
    logic [PHASE_W-1:0] wait_q;

    // Any-hit detection per group
    genvar g;
    generate
        for (g = 0; g < GPB; g++) begin : gen_grp
            assign grp_any[g] = |grp_hits[g*CPG +: CPG];
        end
    endgenerate

    // Number of groups with at least one hit
    always_comb begin
        cnt_now = '0;
        for (int i = 0; i < GPB; i++) begin
            cnt_now = cnt_now + PART_W'(grp_any[i]);
        end
    end

    assign capture = armed_q && (wait_q == '0);

    // Phase countdown from strobe edge to capture point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            wait_q  <= '0;
        end else if (strobe_rise) begin
            armed_q <= 1'b1;
            wait_q  <= phase;
        end else if (capture) begin
            armed_q <= 1'b0;
        end else if (armed_q) begin
            wait_q  <= wait_q - 1'b1;
        end
    end

    // Partial count register: free running or strobe captured
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part <= '0;
        end else if (!strobe_mode || capture) begin
            part <= cnt_now;
        end
    end
endmodule

// File: rtl/tmult_tree.sv
// Module: tmult_tree
// Tray-level adder: sums all board partial counts and clamps at MAX_COUNT.
// Assumes: parts are registered by the board slices.
module tmult_tree #(
    parameter int NB        = 8,
    parameter int PART_W    = 2,
    parameter int SUM_W     = 5,
    parameter int MAX_COUNT = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NB*PART_W-1:0] parts,
    output logic [SUM_W-1:0]     total
);
    logic [SUM_W:0] acc;

    // Adder over all board slices
    always_comb begin
        acc = '0;
        for (int b = 0; b < NB; b++) begin
            acc = acc + (SUM_W+1)'(parts[b*PART_W +: PART_W]);
        end
    end

    // Registered, saturated total
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total <= '0;
        end else if (acc > (SUM_W+1)'(MAX_COUNT)) begin
            total <= SUM_W'(MAX_COUNT);
        end else begin
            total <= acc[SUM_W-1:0];
        end
    end
endmodule

// File: rtl/tmult_emit.sv
// Module: tmult_emit
// Output stage: selectable delay line followed by a pulse stretcher.
// Assumes: delay and stretch settings are quasi-static.
module tmult_emit #(
    parameter int SUM_W     = 5,
    parameter int DELAY_W   = 4,
    parameter int STRETCH_W = 4,
    parameter int MAX_DELAY = (1 << DELAY_W) - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SUM_W-1:0]     total,
    input  logic [DELAY_W-1:0]   delay,
    input  logic [STRETCH_W-1:0] stretch,
    output logic [SUM_W-1:0]     value
);
    logic [SUM_W-1:0]     tap_q [MAX_DELAY];
    logic [SUM_W-1:0]     src;
    logic [STRETCH_W-1:0] hold_q;

    // Shift register of past totals
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_DELAY; i++) tap_q[i] <= '0;
        end else begin
            tap_q[0] <= total;
            for (int i = 1; i < MAX_DELAY; i++) tap_q[i] <= tap_q[i-1];
        end
    end

    // Tap select for the programmed delay
    always_comb begin
        src = total;
        for (int i = 1; i <= MAX_DELAY; i++) begin
            if (int'(delay) == i) src = tap_q[i-1];
        end
    end

    // Stretcher: hold a loaded non-zero value for the programmed cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value  <= '0;
            hold_q <= '0;
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end else begin
            value <= src;
            if (src != '0 && stretch != '0) hold_q <= stretch - 1'b1;
        end
    end
endmodule

// File: rtl/tray_mult_sum.sv
// Module: tray_mult_sum (top)
// Fast tray multiplicity: synchronizes hits, counts hit groups per board,
// sums across boards with saturation and drives a delayed, stretched output.
// Assumes: hits and trig_strobe are asynchronous to clk; the strobe period is
// longer than the synchronizer plus the largest phase.
module tray_mult_sum #(
    parameter int NB  = 8,
    parameter int GPB = 3,
    parameter int CPG = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NB*GPB*CPG-1:0]                hits,
    input  logic                                 strobe_mode,
    input  logic                                 trig_strobe,
    input  logic [NB*tmult_pkg::PHASE_W-1:0]     board_phase,
    input  logic [tmult_pkg::DELAY_W-1:0]        out_delay,
    input  logic [tmult_pkg::STRETCH_W-1:0]      stretch_cycles,
    output logic [$clog2(NB*GPB+1)-1:0]          mult_out
);
    import tmult_pkg::*;

    localparam int NCH       = NB * GPB * CPG;
    localparam int CH_PER_BD = GPB * CPG;
    localparam int PART_W    = $clog2(GPB + 1);
    localparam int SUM_W     = $clog2(NB * GPB + 1);
    localparam int MAX_COUNT = NB * GPB;

    logic [NCH-1:0]       hits_s;
    logic                 strb_s;
    logic                 strb_d;
    logic                 strobe_rise;
    logic [NB*PART_W-1:0] part_all;
    logic [NB-1:0]        cap_all;
    logic [SUM_W-1:0]     total;

    tmult_sync #(.W(NCH)) u_hit_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (hits),
        .d_sync  (hits_s)
    );

    tmult_sync #(.W(1)) u_strb_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (trig_strobe),
        .d_sync  (strb_s)
    );

    // Previous strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) strb_d <= 1'b0;
        else        strb_d <= strb_s;
    end

    assign strobe_rise = strb_s && !strb_d;

    genvar b;
    generate
        for (b = 0; b < NB; b++) begin : gen_board
            tmult_board #(
                .CPG     (CPG),
                .GPB     (GPB),
                .PHASE_W (PHASE_W),
                .PART_W  (PART_W)
            ) u_board (
                .clk         (clk),
                .rst_n       (rst_n),
                .grp_hits    (hits_s[b*CH_PER_BD +: CH_PER_BD]),
                .strobe_mode (strobe_mode),
                .strobe_rise (strobe_rise),
                .phase       (board_phase[b*PHASE_W +: PHASE_W]),
                .part        (part_all[b*PART_W +: PART_W]),
                .capture     (cap_all[b])
            );
        end
    endgenerate

    tmult_tree #(
        .NB        (NB),
        .PART_W    (PART_W),
        .SUM_W     (SUM_W),
        .MAX_COUNT (MAX_COUNT)
    ) u_tree (
        .clk   (clk),
        .rst_n (rst_n),
        .parts (part_all),
        .total (total)
    );

    tmult_emit #(
        .SUM_W     (SUM_W),
        .DELAY_W   (DELAY_W),
        .STRETCH_W (STRETCH_W)
    ) u_emit (
        .clk     (clk),
        .rst_n   (rst_n),
        .total   (total),
        .delay   (out_delay),
        .stretch (stretch_cycles),
        .value   (mult_out)
    );
endmodule

// File: rtl/tray_mult_sum_chk.sv
// Module: tray_mult_sum_chk
// Property checker bound into tray_mult_sum.
// Assumes: stretch setting is not changed while a value is held.
module tray_mult_sum_chk #(
    parameter int SUM_W     = 5,
    parameter int NB        = 8,
    parameter int PART_W    = 2,
    parameter int MAX_COUNT = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 strobe_mode,
    input logic [3:0]           stretch_cycles,
    input logic [SUM_W-1:0]     mult_out,
    input logic [NB*PART_W-1:0] part_all,
    input logic [NB-1:0]        cap_all
);
    // R3
    out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mult_out <= SUM_W'(MAX_COUNT));

    // R4
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> mult_out == '0);

    // R7
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mult_out != '0 && $past(mult_out) == '0 && stretch_cycles > 4'd1)
        |=> $stable(mult_out));

    // R8
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_mode && cap_all == '0) |=> $stable(part_all));
endmodule

bind tray_mult_sum tray_mult_sum_chk #(
    .SUM_W     (SUM_W),
    .NB        (NB),
    .PART_W    (PART_W),
    .MAX_COUNT (MAX_COUNT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobe_mode    (strobe_mode),
    .stretch_cycles (stretch_cycles),
    .mult_out       (mult_out),
    .part_all       (part_all),
    .cap_all        (cap_all)
);

// File: tb/tray_mult_sum_test.sv
module tray_mult_sum_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [191:0] hits = '0;
    logic         strobe_mode = 1'b0;
    logic         trig_strobe = 1'b0;
    logic [15:0]  board_phase = '0;
    logic [3:0]   out_delay = '0;
    logic [3:0]   stretch_cycles = 4'd1;
    logic [4:0]   mult_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    tray_mult_sum uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .hits           (hits),
        .strobe_mode    (strobe_mode),
        .trig_strobe    (trig_strobe),
        .board_phase    (board_phase),
        .out_delay      (out_delay),
        .stretch_cycles (stretch_cycles),
        .mult_out       (mult_out)
    );

    function automatic int groups_hit(logic [191:0] h);
        int n = 0;
        for (int g = 0; g < 24; g++) if (|h[g*8 +: 8]) n++;
        return (n > 24) ? 24 : n;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // R4: output cleared by reset
    task automatic t_reset();
        cyc(3);
        chk("R4 reset", int'(mult_out), 0);
        rst_n = 1'b1;
        cyc(3);
        chk("R4 after reset", int'(mult_out), 0);
    endtask

    // R1 R2 R3: group counting and saturation in self-latch mode
    task automatic t_groups();
        logic [191:0] p;
        strobe_mode = 1'b0; out_delay = '0; stretch_cycles = 4'd1;
        p = '0; p[0] = 1'b1;
        hits = p; cyc(12); chk("R1 single hit", int'(mult_out), 1);
        p = '0; p[7:0] = 8'hFF;
        hits = p; cyc(12); chk("R1 full group counts once", int'(mult_out), 1);
        p = '0; p[191:168] = {24{1'b1}};
        hits = p; cyc(12); chk("R2 board 7 all groups", int'(mult_out), 3);
        p = '0; for (int g = 0; g < 24; g++) p[g*8 + (g % 8)] = 1'b1;
        hits = p; cyc(12); chk("R2 one hit per group", int'(mult_out), 24);
        p = '0; p[3] = 1'b1; p[5] = 1'b1; p[30] = 1'b1; p[100] = 1'b1; p[103] = 1'b1; p[190] = 1'b1;
        hits = p; cyc(12); chk("R2 mixed pattern", int'(mult_out), groups_hit(p));
        hits = '1; cyc(12); chk("R3 all channels saturate", int'(mult_out), 24);
        hits = '0; cyc(12); chk("R2 no hits", int'(mult_out), 0);
    endtask

    // R5 R6: exact latency for a given delay
    task automatic t_latency(int d);
        logic [191:0] p;
        strobe_mode = 1'b0; stretch_cycles = 4'd1; out_delay = 4'(d);
        hits = '0; cyc(30);
        p = '0; p[40] = 1'b1; p[90] = 1'b1;
        hits = p;
        for (int n = 1; n <= 5 + d; n++) begin
            @(posedge clk); @(negedge clk);
            if (n == 4 + d) chk($sformatf("R6 delay %0d before edge", d), int'(mult_out), 0);
            if (n == 5 + d) chk($sformatf("R5 delay %0d latency", d), int'(mult_out), 2);
        end
        hits = '0; cyc(30);
    endtask

    // R7: single-cycle pulse stretched to max(1,S) cycles
    task automatic t_stretch(int s);
        int nz = 0;
        strobe_mode = 1'b0; out_delay = '0; stretch_cycles = 4'(s);
        hits = '0; cyc(30);
        hits[10] = 1'b1;
        cyc(1);
        hits = '0;
        for (int n = 0; n < 40; n++) begin
            cyc(1);
            if (mult_out != '0) nz++;
        end
        chk($sformatf("R7 stretch %0d cycles", s), nz, (s == 0) ? 1 : s);
        stretch_cycles = 4'd1;
    endtask

    task automatic pulse_strobe();
        trig_strobe = 1'b1; cyc(4);
        trig_strobe = 1'b0; cyc(30);
    endtask

    // R8: strobe mode holds between strobes
    task automatic t_strobe_hold();
        logic [191:0] a, b;
        strobe_mode = 1'b1; board_phase = '0; out_delay = '0; stretch_cycles = 4'd1;
        a = '0; a[0] = 1'b1; a[50] = 1'b1; a[60] = 1'b1;
        b = '0; b[100] = 1'b1;
        hits = a; cyc(5); pulse_strobe();
        chk("R8 captured at strobe", int'(mult_out), 3);
        hits = b; cyc(30);
        chk("R8 hits ignored between strobes", int'(mult_out), 3);
        pulse_strobe();
        chk("R8 next strobe updates", int'(mult_out), 1);
    endtask

    // R9: per-board capture phase
    task automatic t_phase();
        logic [191:0] p;
        strobe_mode = 1'b1; out_delay = '0; stretch_cycles = 4'd1;
        board_phase = '0; board_phase[1:0] = 2'd3; board_phase[3:2] = 2'd0;
        hits = '0; cyc(5); pulse_strobe();
        chk("R9 cleared by strobe", int'(mult_out), 0);
        p = '0; p[0] = 1'b1; p[24] = 1'b1; p[32] = 1'b1;
        trig_strobe = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        hits = p;
        cyc(30);
        chk("R9 phase 3 sees late hit, phase 0 does not", int'(mult_out), 1);
        trig_strobe = 1'b0; cyc(10);
        pulse_strobe();
        chk("R9 both boards after second strobe", int'(mult_out), 3);
        board_phase = '0;
    endtask

    // R5: strobe ignored in self-latch mode
    task automatic t_self_ignores_strobe();
        logic [191:0] c, d;
        strobe_mode = 1'b0; out_delay = '0; stretch_cycles = 4'd1;
        c = '0; c[8] = 1'b1; c[16] = 1'b1; c[150] = 1'b1;
        d = '0; d[180] = 1'b1;
        hits = c;
        for (int i = 0; i < 4; i++) begin
            trig_strobe = ~trig_strobe; cyc(3);
        end
        cyc(10);
        chk("R5 self mode follows hits with strobe toggling", int'(mult_out), 3);
        hits = d; cyc(12);
        chk("R5 self mode follows hits without strobe", int'(mult_out), 1);
        trig_strobe = 1'b0; hits = '0; cyc(12);
    endtask

    initial begin
        t_reset();
        t_groups();
        t_latency(0);
        t_latency(7);
        t_latency(15);
        t_stretch(6);
        t_stretch(0);
        t_self_ignores_strobe();
        t_strobe_hold();
        t_phase();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end
endmodule